// File: doc/BRIEF.md
# USB OTG B-Device Session Request Sequencer

This block sits between the control logic of a USB On-The-Go B-device and its transceiver. It handles two jobs. First, it watches the bus for idleness and raises early-suspend and suspend flags. Once the bus is suspended, it asks the transceiver to discharge VBUS. Second, it carries out the Session Request Protocol when software asks for a new session.

The sequencer waits until the B-session has ended and the bus has sat in SE0 for long enough. It then drives a D+ pulse, followed by a VBUS charge pulse. After that it waits for the host to switch VBUS back on. It reports either success or a timeout through sticky flags, and those flags drive an interrupt line.

All time is counted in periods of a millisecond tick input, so the clock frequency does not matter. Line state is encoded as 2'b00 = SE0, 2'b01 = J (idle), 2'b10 = K and 2'b11 = SE1.

Top module: `otg_srp_seq`

## Requirements
- R1: The idle count advances once per `ms_tick` while `line_state` is 2'b01 (J). `flag_esusp` sets once the count reaches ESUSP_MS (default 3). Any other line state clears the count.
- R2: `flag_susp` sets once the idle count reaches SUSP_MS (default 4). From that point `dischrg_req` is high while `bsess_vld` is high. Resume (line 2'b10 or 2'b11) or a rising `vbus_vld` ends the suspended condition.
- R3: `fast_dischrg_req` is high while both `bsess_vld` and `vbus_vld` are low, except during the charge pulse.
- R4: A one-cycle `srp_req_set` pulse in idle sets `srp_busy`. The sequence starts only once two conditions hold together: `bsess_vld` is low, and the line has been 2'b00 (SE0) for at least SE0_MS ticks (default 2). Until then it waits.
- R5: The sequence drives `dp_pulse` for DP_MS ticks (default 7). It then drives `chrg_vbus` for CHG_MS ticks (default 15). After that it waits with both low.
- R6: `vbus_vld` high in any active phase ends the sequence. It sets `flag_ok` and clears `srp_busy`.
- R7: Suppose TMO_MS ticks (default 5000) pass from the start of the D+ pulse without `vbus_vld`. Then `flag_fail` sets, `srp_busy` clears, and both pulses stop.
- R8: `chrg_vbus` is never high together with `dischrg_req`, `fast_dischrg_req` or `dp_pulse`.
- R9: `srp_req_set` while `srp_busy` is high has no effect. It does not change the pulse timing and does not restart the sequence after it completes.
- R10: Flags are sticky. `irq_clr` bits (0 esusp, 1 susp, 2 ok, 3 fail) clear them when written as one. `irq` is the OR of the four flags.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| bsess_vld | input | 1 | B-session valid from transceiver |
| vbus_vld | input | 1 | VBUS valid from transceiver |
| srp_req_set | input | 1 | Software request pulse |
| irq_clr | input | 4 | Write-one-to-clear flag bits |
| srp_busy | output | 1 | Session request bit, self-clearing |
| dp_pulse | output | 1 | Drive D+ high (data-line pulse) |
| chrg_vbus | output | 1 | VBUS charge pulse request |
| dischrg_req | output | 1 | VBUS discharge request |
| fast_dischrg_req | output | 1 | Accelerated VBUS discharge request |
| flag_esusp | output | 1 | Early-suspend flag |
| flag_susp | output | 1 | Suspend flag |
| flag_ok | output | 1 | Session request success flag |
| flag_fail | output | 1 | Session request timeout flag |
| irq | output | 1 | Interrupt, OR of flags |

## Verification
The assertions assume a well-behaved transceiver: `vbus_vld` is never high while `bsess_vld` is low. They also assume `ms_tick` is a single-cycle pulse separated by idle cycles. The stimulus respects both. It raises `bsess_vld` no later than `vbus_vld` and lowers it no earlier. It spaces ticks four clocks apart. It changes inputs only on the falling clock edge, one cycle or more before each tick.

// File: rtl/otg_srp_pkg.sv
package otg_srp_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_DPULSE,
    SQ_VPULSE,
    SQ_WVBUS
  } sq_state_t;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;

  localparam int FI_ESUSP = 0;
  localparam int FI_SUSP  = 1;
  localparam int FI_OK    = 2;
  localparam int FI_FAIL  = 3;
  localparam int N_FLAGS  = 4;
endpackage

// File: rtl/otg_ms_span.sv
module otg_ms_span #(
  parameter int LIMIT = 4,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (!run)
      cnt_n = '0;
    else if (tick && (cnt < W'(LIMIT)))
      cnt_n = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/otg_flag_bank.sv
module otg_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic en;
    logic d;
    assign en = set[i] | clr[i];
    assign d  = set[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags[i] <= 1'b0;
      else if (en) flags[i] <= d;
    end
  end

  assign irq = |flags;
endmodule

// File: rtl/otg_srp_fsm.sv
module otg_srp_fsm
  import otg_srp_pkg::*;
#(
  parameter int DP_MS  = 7,
  parameter int CHG_MS = 15,
  parameter int TMO_MS = 5000,
  localparam int TMAX = (DP_MS > CHG_MS) ? DP_MS : CHG_MS,
  localparam int TW   = $clog2(TMAX + 1),
  localparam int OW   = $clog2(TMO_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req_set,
  input  logic bsess_vld,
  input  logic vbus_vld,
  input  logic se0_ok,
  output logic busy,
  output logic dp_pulse,
  output logic chrg,
  output logic chrg_next,
  output logic done_ok,
  output logic done_fail
);
  sq_state_t st, st_n;
  logic [TW-1:0] tmr, tmr_n;
  logic [OW-1:0] tmo, tmo_n;
  logic active;

  assign active = (st == SQ_DPULSE) || (st == SQ_VPULSE) || (st == SQ_WVBUS);

  always_comb begin
    st_n      = st;
    tmr_n     = tmr;
    tmo_n     = tmo;
    done_ok   = 1'b0;
    done_fail = 1'b0;
    case (st)
      SQ_IDLE: if (req_set) st_n = SQ_WAIT;
      SQ_WAIT: begin
        if (!bsess_vld && se0_ok) begin
          st_n  = SQ_DPULSE;
          tmr_n = '0;
          tmo_n = '0;
        end
      end
      default: begin
        if (active && vbus_vld) begin
          done_ok = 1'b1;
          st_n    = SQ_IDLE;
        end else if (active && tick && (tmo == OW'(TMO_MS - 1))) begin
          done_fail = 1'b1;
          st_n      = SQ_IDLE;
        end else if (active && tick) begin
          tmo_n = tmo + OW'(1);
          if (st == SQ_DPULSE) begin
            if (tmr == TW'(DP_MS - 1)) begin
              st_n  = SQ_VPULSE;
              tmr_n = '0;
            end else tmr_n = tmr + TW'(1);
          end else if (st == SQ_VPULSE) begin
            if (tmr == TW'(CHG_MS - 1)) begin
              st_n  = SQ_WVBUS;
              tmr_n = '0;
            end else tmr_n = tmr + TW'(1);
          end
        end else if (!active) begin
          st_n = SQ_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      tmr <= '0;
      tmo <= '0;
    end else begin
      st  <= st_n;
      tmr <= tmr_n;
      tmo <= tmo_n;
    end
  end

  assign busy      = (st != SQ_IDLE);
  assign dp_pulse  = (st == SQ_DPULSE);
  assign chrg      = (st == SQ_VPULSE);
  assign chrg_next = (st_n == SQ_VPULSE);
endmodule

// File: rtl/otg_srp_seq.sv
module otg_srp_seq
  import otg_srp_pkg::*;
#(
  parameter int ESUSP_MS = 3,
  parameter int SUSP_MS  = 4,
  parameter int SE0_MS   = 2,
  parameter int DP_MS    = 7,
  parameter int CHG_MS   = 15,
  parameter int TMO_MS   = 5000,
  localparam int IW = $clog2(SUSP_MS + 1),
  localparam int SW = $clog2(SE0_MS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [1:0] line_state,
  input  logic       bsess_vld,
  input  logic       vbus_vld,
  input  logic       srp_req_set,
  input  logic [3:0] irq_clr,
  output logic       srp_busy,
  output logic       dp_pulse,
  output logic       chrg_vbus,
  output logic       dischrg_req,
  output logic       fast_dischrg_req,
  output logic       flag_esusp,
  output logic       flag_susp,
  output logic       flag_ok,
  output logic       flag_fail,
  output logic       irq
);
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] se0_cnt;
  logic esusp_lvl, susp_lvl, esusp_q, susp_q, vbus_q;
  logic susp_act, susp_act_n;
  logic dis_n, fast_n;
  logic resume;
  logic chrg_next, done_ok, done_fail;
  logic [N_FLAGS-1:0] fset, flags;

  otg_ms_span #(.LIMIT(SUSP_MS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick),
    .run(line_state == LS_J), .cnt(idle_cnt)
  );

  otg_ms_span #(.LIMIT(SE0_MS)) u_se0 (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick),
    .run(line_state == LS_SE0), .cnt(se0_cnt)
  );

  otg_srp_fsm #(.DP_MS(DP_MS), .CHG_MS(CHG_MS), .TMO_MS(TMO_MS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .req_set(srp_req_set),
    .bsess_vld(bsess_vld), .vbus_vld(vbus_vld),
    .se0_ok(se0_cnt >= SW'(SE0_MS)),
    .busy(srp_busy), .dp_pulse(dp_pulse), .chrg(chrg_vbus),
    .chrg_next(chrg_next), .done_ok(done_ok), .done_fail(done_fail)
  );

  assign esusp_lvl = (idle_cnt >= IW'(ESUSP_MS));
  assign susp_lvl  = (idle_cnt >= IW'(SUSP_MS));
  assign resume    = line_state[1] || (vbus_vld && !vbus_q);

  always_comb begin
    susp_act_n = susp_act;
    if (resume)                 susp_act_n = 1'b0;
    else if (susp_lvl && !susp_q) susp_act_n = 1'b1;
    dis_n  = susp_act_n && bsess_vld && !chrg_next;
    fast_n = !bsess_vld && !vbus_vld && !chrg_next;
  end

  always_comb begin
    fset           = '0;
    fset[FI_ESUSP] = esusp_lvl && !esusp_q;
    fset[FI_SUSP]  = susp_lvl && !susp_q;
    fset[FI_OK]    = done_ok;
    fset[FI_FAIL]  = done_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esusp_q          <= 1'b0;
      susp_q           <= 1'b0;
      vbus_q           <= 1'b0;
      susp_act         <= 1'b0;
      dischrg_req      <= 1'b0;
      fast_dischrg_req <= 1'b0;
    end else begin
      esusp_q          <= esusp_lvl;
      susp_q           <= susp_lvl;
      vbus_q           <= vbus_vld;
      susp_act         <= susp_act_n;
      dischrg_req      <= dis_n;
      fast_dischrg_req <= fast_n;
    end
  end

  otg_flag_bank #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(irq_clr),
    .flags(flags), .irq(irq)
  );

  assign flag_esusp = flags[FI_ESUSP];
  assign flag_susp  = flags[FI_SUSP];
  assign flag_ok    = flags[FI_OK];
  assign flag_fail  = flags[FI_FAIL];
endmodule

// File: rtl/otg_srp_seq_chk.sv
module otg_srp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bsess_vld,
  input logic srp_busy,
  input logic dp_pulse,
  input logic chrg_vbus,
  input logic dischrg_req,
  input logic fast_dischrg_req,
  input logic flag_ok,
  input logic flag_fail
);
  a_r8_no_chrg_with_dischrg: assert property (@(posedge clk) disable iff (!rst_n)
    !(chrg_vbus && (dischrg_req || fast_dischrg_req)));

  a_r8_dp_chrg_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_pulse && chrg_vbus));

  a_r4_start_after_sess_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_pulse) |-> !$past(bsess_vld));

  a_r5_chrg_follows_dp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrg_vbus) |-> $past(dp_pulse));

  a_r7_busy_ends_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srp_busy) |-> (flag_ok || flag_fail));

  a_r6_ok_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ok) |-> !$rose(flag_fail));
endmodule

bind otg_srp_seq otg_srp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bsess_vld(bsess_vld), .srp_busy(srp_busy),
  .dp_pulse(dp_pulse), .chrg_vbus(chrg_vbus), .dischrg_req(dischrg_req),
  .fast_dischrg_req(fast_dischrg_req), .flag_ok(flag_ok), .flag_fail(flag_fail)
);

// File: tb/otg_srp_seq_tb.sv
module otg_srp_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;

  logic clk, rst_n, ms_tick, bsess_vld, vbus_vld, srp_req_set;
  logic [1:0] line_state;
  logic [3:0] irq_clr;
  logic srp_busy, dp_pulse, chrg_vbus, dischrg_req, fast_dischrg_req;
  logic flag_esusp, flag_susp, flag_ok, flag_fail, irq;
  int n_chk, n_fail;
  logic done;

  otg_srp_seq #(.TMO_MS(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .line_state(line_state),
    .bsess_vld(bsess_vld), .vbus_vld(vbus_vld), .srp_req_set(srp_req_set),
    .irq_clr(irq_clr), .srp_busy(srp_busy), .dp_pulse(dp_pulse),
    .chrg_vbus(chrg_vbus), .dischrg_req(dischrg_req),
    .fast_dischrg_req(fast_dischrg_req), .flag_esusp(flag_esusp),
    .flag_susp(flag_susp), .flag_ok(flag_ok), .flag_fail(flag_fail), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // line[11:10] bsess[9] vbus[8] ticks[7:4] expect{esusp,susp,dis,fast}[3:0]
  localparam logic [11:0] VEC [7] = '{
    12'b01_1_1_0010_0000,
    12'b10_1_1_0001_0000,
    12'b01_1_1_0010_0000,
    12'b01_1_1_0001_1000,
    12'b01_1_1_0001_1110,
    12'b01_1_0_0000_1110,
    12'b00_0_0_0000_1101
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic req_pulse();
    @(negedge clk) srp_req_set = 1'b1;
    @(negedge clk) srp_req_set = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk) irq_clr = 4'hF;
    @(negedge clk) irq_clr = 4'h0;
    @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; ms_tick = 1'b0; line_state = 2'b01; bsess_vld = 1'b1;
    vbus_vld = 1'b1; srp_req_set = 1'b0; irq_clr = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset outputs",
        {srp_busy, dp_pulse, chrg_vbus, dischrg_req, fast_dischrg_req,
         flag_esusp, flag_susp, flag_ok, flag_fail, irq}, 0);

    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      line_state = VEC[k][11:10];
      bsess_vld  = VEC[k][9];
      vbus_vld   = VEC[k][8];
      repeat (3) @(negedge clk);
      tick_n(int'(VEC[k][7:4]));
      chk($sformatf("R1 R2 R3 vector %0d", k),
          {flag_esusp, flag_susp, dischrg_req, fast_dischrg_req}, VEC[k][3:0]);
    end

    chk("R10 irq with flags set", irq, 1);
    clr_all();
    chk("R10 flags cleared", {flag_esusp, flag_susp, flag_ok, flag_fail, irq}, 0);

    // First request: waits for SE0 time, then pulses, host answers
    req_pulse();
    chk("R4 busy set", srp_busy, 1);
    chk("R4 waiting for SE0", dp_pulse, 0);
    tick_n(1);
    chk("R4 still waiting at 1 tick of SE0", dp_pulse, 0);
    tick_n(1);
    chk("R4 starts after SE0 time", dp_pulse, 1);
    req_pulse();
    tick_n(6);
    chk("R5 R9 data pulse held", {dp_pulse, chrg_vbus}, 2'b10);
    tick_n(1);
    chk("R5 charge after data pulse", {dp_pulse, chrg_vbus}, 2'b01);
    chk("R8 R3 discharge off while charging", {dischrg_req, fast_dischrg_req}, 0);
    tick_n(14);
    chk("R5 charge held", chrg_vbus, 1);
    tick_n(1);
    chk("R5 charge ended, waiting", {srp_busy, chrg_vbus, fast_dischrg_req}, 3'b101);
    @(negedge clk) begin bsess_vld = 1'b1; vbus_vld = 1'b1; line_state = 2'b01; end
    repeat (2) @(negedge clk);
    chk("R6 success", {flag_ok, flag_fail, srp_busy, irq}, 4'b1001);
    clr_all();

    // Second request: no host response, timeout
    @(negedge clk) begin vbus_vld = 1'b0; bsess_vld = 1'b0; line_state = 2'b00; end
    tick_n(2);
    req_pulse();
    chk("R4 immediate start", dp_pulse, 1);
    tick_n(TMO - 1);
    chk("R7 no fail before timeout", {flag_fail, srp_busy}, 2'b01);
    tick_n(1);
    chk("R7 timeout", {flag_fail, flag_ok, srp_busy, dp_pulse, chrg_vbus}, 5'b10000);
    clr_all();

    // Third request: blocked by session still valid; early host response
    @(negedge clk) bsess_vld = 1'b1;
    req_pulse();
    tick_n(3);
    chk("R4 blocked by valid session", {srp_busy, dp_pulse}, 2'b10);
    @(negedge clk) bsess_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 starts at session end", dp_pulse, 1);
    req_pulse();
    @(negedge clk) begin bsess_vld = 1'b1; vbus_vld = 1'b1; end
    repeat (2) @(negedge clk);
    chk("R6 success during data pulse", {flag_ok, srp_busy, dp_pulse}, 3'b100);
    repeat (4) @(negedge clk);
    chk("R9 no restart after busy write", srp_busy, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule